// File: doc/BRIEF.md
# Registered Four-Bit Arithmetic and Logic Unit

This block is a small execution datapath. On every clock edge it captures two operands and a four-bit operation code into registers. From those registered values it computes one of sixteen micro-operations in combinational logic. It then registers the result together with four status flags: overflow, zero, sign and carry.

Opcode bit 3 picks the section that drives the result. When it is clear, an arithmetic section drives the result: a ripple adder whose second operand is chosen by opcode bits 2..1 and whose carry-in is opcode bit 0. When it is set, a logic-and-shift section drives the result. That section is a row of one-bit slices, and each slice also sees its neighbouring operand bits for shifts and rotates.

A new operation may be presented on every clock. Its result appears on the output registers one edge after the edge that captured it.

Top module: `nibbleAlu`

## Requirements
- R1: A synchronous active-high reset clears the captured operands, the captured opcode, the result and all four flags to 0; while `rst` is high at an edge, every output reads 0 after that edge.
- R2: Inputs captured at edge k produce their result and flags at edge k+1. Operations presented on consecutive clocks each yield their own result on consecutive clocks.
- R3: With opcode bit 3 = 0, opcode bits 2..0 select the arithmetic operation: 000 A, 001 A+1, 010 A+B, 011 A+B+1, 100 A+~B, 101 A−B (A+~B+1), 110 A−1 (A plus all ones), 111 A (A plus all ones plus 1). Every result is taken modulo 16.
- R4: With opcode bit 3 = 1, codes 000, 001, 010 and 011 give bitwise AND, OR, XOR and NOT A.
- R5: Code 1100 shifts A left by one place and code 1101 shifts A right by one place; in both cases the vacated bit is filled with 0.
- R6: Code 1110 rotates A left by one place and code 1111 rotates A right by one place.
- R7: The carry flag equals the adder carry-out for arithmetic codes and is 0 for every logic or shift code.
- R8: The overflow flag is the XOR of the carry into bit 3 and the carry out of bit 3 for arithmetic codes (signed two's-complement overflow), and is 0 for logic or shift codes.
- R9: The sign flag equals result bit 3. The zero flag is 1 exactly when all four result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| opCode | input | 4 | Operation select; bit 3 chooses the section |
| result | output | 4 | Registered result |
| flagV | output | 1 | Registered signed overflow flag |
| flagZ | output | 1 | Registered zero flag |
| flagN | output | 1 | Registered sign flag (result bit 3) |
| flagC | output | 1 | Registered carry flag |

## Verification
At a single edge, the block captures a new operand pair and opcode while it registers the result of the pair captured one edge earlier. The bench provokes this overlap by presenting a vector table on consecutive clocks, so that arithmetic and logic codes alternate with no idle cycle between them. Each output sample is judged against the vector presented two negative edges before it, which exposes any mix-up between neighbouring operations in the pipeline. A synchronous reset raised while operations are still in flight is also checked: the outputs must be all zero at once, and the next output, computed from the cleared input registers, must read as a pass-through of zero.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [2:0] {
    LOP_AND = 3'b000,
    LOP_OR  = 3'b001,
    LOP_XOR = 3'b010,
    LOP_NOT = 3'b011,
    LOP_SHL = 3'b100,
    LOP_SHR = 3'b101,
    LOP_ROL = 3'b110,
    LOP_ROR = 3'b111
  } logicOpE;

  // second adder operand, chosen by opcode bits 2..1
  typedef enum logic [1:0] {
    ADD_ZERO = 2'b00,
    ADD_B    = 2'b01,
    ADD_NB   = 2'b10,
    ADD_ONES = 2'b11
  } addSelE;

  typedef struct packed {
    logic    selLogic;
    addSelE  addSel;
    logic    carryIn;
    logicOpE logicOp;
    logic    rotate;
  } aluStrobeT;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opCode,
  output aluStrobeT  strobes
);

  logic [3:0] opReg;

  always_ff @(posedge clk) begin
    if (rst) opReg <= '0;
    else     opReg <= opCode;
  end

  always_comb begin
    strobes.selLogic = opReg[3];
    strobes.addSel   = addSelE'(opReg[2:1]);
    strobes.carryIn  = opReg[0];
    strobes.logicOp  = logicOpE'(opReg[2:0]);
    strobes.rotate   = opReg[2] & opReg[1];
  end

endmodule

// File: rtl/aluArith.sv
module aluArith
  import aluPkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  addSelE       addSel,
  input  logic         carryIn,
  output logic [W-1:0] sum,
  output logic         carryOut,
  output logic         carryIntoMsb
);

  logic [W-1:0] addend;
  logic [W:0]   chain;

  always_comb begin
    unique case (addSel)
      ADD_ZERO: addend = '0;
      ADD_B:    addend = b;
      ADD_NB:   addend = ~b;
      default:  addend = '1;
    endcase
  end

  assign chain[0] = carryIn;

  for (genvar i = 0; i < W; i++) begin : g_ripple
    assign sum[i]     = a[i] ^ addend[i] ^ chain[i];
    assign chain[i+1] = (a[i] & addend[i]) | (chain[i] & (a[i] ^ addend[i]));
  end

  assign carryOut     = chain[W];
  assign carryIntoMsb = chain[W-1];

endmodule

// File: rtl/aluLogicSlice.sv
module aluLogicSlice
  import aluPkg::*;
(
  input  logic    a,
  input  logic    b,
  input  logic    aLo,
  input  logic    aHi,
  input  logicOpE op,
  output logic    y
);

  always_comb begin
    unique case (op)
      LOP_AND: y = a & b;
      LOP_OR:  y = a | b;
      LOP_XOR: y = a ^ b;
      LOP_NOT: y = ~a;
      LOP_SHL, LOP_ROL: y = aLo;
      default: y = aHi;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobeT    strobes,
  output logic [W-1:0] result,
  output logic         flagV,
  output logic         flagZ,
  output logic         flagN,
  output logic         flagC
);

  logic [W-1:0] aReg, bReg;
  logic [W-1:0] arithSum, logicOut, nextRes;
  logic         arithCout, arithCmsb;
  logic [W-1:0] loNbr, hiNbr;

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg <= '0;
      bReg <= '0;
    end else begin
      aReg <= opA;
      bReg <= opB;
    end
  end

  aluArith #(.W(W)) arith_i (
    .a            (aReg),
    .b            (bReg),
    .addSel       (strobes.addSel),
    .carryIn      (strobes.carryIn),
    .sum          (arithSum),
    .carryOut     (arithCout),
    .carryIntoMsb (arithCmsb)
  );

  for (genvar i = 0; i < W; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      assign loNbr[i] = strobes.rotate ? aReg[W-1] : 1'b0;
    end else begin : g_lo
      assign loNbr[i] = aReg[i-1];
    end
    if (i == W-1) begin : g_msb
      assign hiNbr[i] = strobes.rotate ? aReg[0] : 1'b0;
    end else begin : g_hi
      assign hiNbr[i] = aReg[i+1];
    end

    aluLogicSlice slice_i (
      .a   (aReg[i]),
      .b   (bReg[i]),
      .aLo (loNbr[i]),
      .aHi (hiNbr[i]),
      .op  (strobes.logicOp),
      .y   (logicOut[i])
    );
  end

  assign nextRes = strobes.selLogic ? logicOut : arithSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flagV  <= 1'b0;
      flagZ  <= 1'b0;
      flagN  <= 1'b0;
      flagC  <= 1'b0;
    end else begin
      result <= nextRes;
      flagV  <= ~strobes.selLogic & (arithCmsb ^ arithCout);
      flagZ  <= (nextRes == '0);
      flagN  <= nextRes[W-1];
      flagC  <= ~strobes.selLogic & arithCout;
    end
  end

endmodule

// File: rtl/nibbleAlu.sv
module nibbleAlu
  import aluPkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [3:0]   opCode,
  output logic [W-1:0] result,
  output logic         flagV,
  output logic         flagZ,
  output logic         flagN,
  output logic         flagC
);

  aluStrobeT strobes;

  aluCtrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .opCode  (opCode),
    .strobes (strobes)
  );

  aluDatapath #(.W(W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .flagV   (flagV),
    .flagZ   (flagZ),
    .flagN   (flagN),
    .flagC   (flagC)
  );

endmodule

// File: rtl/nibbleAluChk.sv
module nibbleAluChk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [3:0]   opCode,
  input logic [W-1:0] result,
  input logic         flagV,
  input logic         flagZ,
  input logic         flagN,
  input logic         flagC
);

  // counts edges since reset; outputs track inputs once it reaches 2
  logic [1:0] sinceRst;
  logic       ready;

  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  assign ready = (sinceRst == 2'd2);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (result == '0) && !flagV && !flagZ && !flagN && !flagC);

  // R9
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
    ready |-> (flagZ == (result == '0)));

  // R9
  a_r9_sign_flag: assert property (@(posedge clk) disable iff (rst)
    ready |-> (flagN == result[W-1]));

  // R7
  a_r7_no_carry_logic: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(opCode[3], 2)) |-> !flagC);

  // R8
  a_r8_no_overflow_logic: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(opCode[3], 2)) |-> !flagV);

  // R3 and R2
  a_r3_add_result: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(opCode, 2) == 4'b0010) |->
      (result == W'($past(opA, 2) + $past(opB, 2))));

  // R8
  a_r8_add_overflow: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(opCode, 2) == 4'b0010) |->
      (flagV == (($past(opA, 2) >> (W-1)) == ($past(opB, 2) >> (W-1)) &&
                 result[W-1] != $past(opA[W-1], 2))));

  // R4
  a_r4_and_result: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(opCode, 2) == 4'b1000) |->
      (result == ($past(opA, 2) & $past(opB, 2))));

endmodule

bind nibbleAlu nibbleAluChk #(.W(W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .opA    (opA),
  .opB    (opB),
  .opCode (opCode),
  .result (result),
  .flagV  (flagV),
  .flagZ  (flagZ),
  .flagN  (flagN),
  .flagC  (flagC)
);

// File: tb/nibbleAlu_tb_top.sv
module nibbleAlu_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic [3:0] opCode = '0;
  logic [3:0] result;
  logic       flagV, flagZ, flagN, flagC;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nibbleAlu dut_i (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .flagV(flagV), .flagZ(flagZ), .flagN(flagN), .flagC(flagC)
  );

  // fields: opcode, A, B, expected result, expected flags {V,Z,N,C}
  localparam int NV = 23;
  localparam logic [19:0] VEC [NV] = '{
    20'h05350, // R3 A
    20'h1F005, // R3 A+1 wraps, carry R7
    20'h2718A, // R3 A+B signed overflow R8
    20'h36905, // R3 A+B+1 wraps to zero R9
    20'h49269, // R3 A+~B overflow R8
    20'h535E2, // R3 A-B negative
    20'h58179, // R3 A-B overflow R8
    20'h600F2, // R3 A-1 from zero, no carry R7
    20'h68079, // R3 A-1 overflow
    20'h7A4A3, // R3 pass A with carry
    20'h8CA82, // R4 AND
    20'h90004, // R4 OR zero R9
    20'hAFF04, // R4 XOR to zero
    20'hA6350, // R4 XOR
    20'hB50A2, // R4 NOT
    20'hC9020, // R5 shift left
    20'hC8004, // R5 shift left drops msb
    20'hD9040, // R5 shift right
    20'hE9030, // R6 rotate left
    20'hE8010, // R6 rotate left wraps msb
    20'hF90C2, // R6 rotate right
    20'hF1082, // R6 rotate right wraps lsb
    20'hEF0F2  // R7 logic with all ones keeps carry clear
  };

  function automatic string reqOf(input logic [3:0] op);
    if (!op[3])      return "R3";
    else if (!op[2]) return "R4";
    else if (!op[1]) return "R5";
    else             return "R6";
  endfunction

  task automatic check(input string req, input logic [3:0] expRes, input logic [3:0] expFlg);
    logic [3:0] gotFlg;
    gotFlg = {flagV, flagZ, flagN, flagC};
    checks++;
    if (result !== expRes || gotFlg !== expFlg) begin
      failures++;
      $display("FAIL %s result=%h flags(VZNC)=%b expected result=%h flags=%b",
               req, result, gotFlg, expRes, expFlg);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1", 4'h0, 4'b0000);

    // R2 latency: after release the cleared inputs pass zero, then the new op
    opCode = 4'b0010; opA = 4'h7; opB = 4'h1;
    rst = 1'b0;
    @(negedge clk);
    check("R2", 4'h0, 4'b0100);
    opCode = 4'b0000; opA = 4'h0; opB = 4'h0;
    @(negedge clk);
    check("R2", 4'h8, 4'b1010);

    // back-to-back table walk: sample at step i the vector driven at step i-2 (R2)
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2)
        check($sformatf("%s/R2/R7/R8/R9", reqOf(VEC[i-2][19:16])),
              VEC[i-2][7:4], VEC[i-2][3:0]);
      if (i < NV) begin
        opCode = VEC[i][19:16];
        opA    = VEC[i][15:12];
        opB    = VEC[i][11:8];
      end
      @(negedge clk);
    end

    // R1: synchronous reset with a carrying operation in flight
    opCode = 4'b0001; opA = 4'hF; opB = 4'h0;
    @(negedge clk);
    opCode = 4'b1011; opA = 4'h0;
    rst = 1'b1;
    @(negedge clk);
    check("R1", 4'h0, 4'b0000);
    rst = 1'b0;
    opCode = 4'b0000;
    @(negedge clk);
    // inputs were cleared by reset, so pass-through of zero appears
    check("R1", 4'h0, 4'b0100);

    // R7: A-1 of a nonzero value sets carry; R9 sign clear
    opCode = 4'b0110; opA = 4'h3; opB = 4'h0;
    @(negedge clk);
    @(negedge clk);
    check("R7", 4'h2, 4'b0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule